// File: doc/BRIEF.md
# Modem Line Status Register

This block watches a small group of incoming modem control lines and folds them into one status byte for a host to read. Each line is first brought into the local clock domain by a synchronizer chain. The upper half of the byte shows the present synchronized level of every line. The lower half holds one sticky flag per line. A flag is set whenever its line has toggled since the host last read the byte.

The host reads by pulsing a read strobe for one clock. The byte on the read-data output during that cycle is the value from before the read. At the clock edge that ends the cycle, every change flag is cleared. There is one exception: a line whose toggle is detected in that same cycle keeps its flag set, so the event is not lost. While any flag is set and the enable input is high, an interrupt request is raised. Read data and interrupt are plain combinational status outputs, so there is no handshake and no back-pressure.

Top module: `modem_status_reg`

## Requirements
- R1: `rd_data[4+i]` shows the level of `modem_in[i]` as it was two rising clock edges earlier; it is unaffected by reads.
- R2: A toggle on `modem_in[i]` sets `rd_data[i]` at the third rising edge after the input changed, which is one edge after the new level appears in the upper half.
- R3: A set change flag stays set until a read, including when its line toggles back to its earlier level.
- R4: A cycle with `rd_en` high clears every change flag at the closing edge, except a flag whose line has a toggle detected in that same cycle; such a flag ends up set.
- R5: During a cycle with `rd_en` high, `rd_data` carries the pre-clear value: levels in bits 7:4 and flags in bits 3:0.
- R6: `irq` is high exactly when `irq_en` is high and at least one of `rd_data[3:0]` is set.
- R7: During reset all change flags are held at zero while the level bits follow the synchronized inputs, so stable inputs produce no flag after reset is released.
- R8: A read while no flag is set leaves `rd_data` unchanged.
- R9: Lines are independent: a toggle on one line sets only that line's flag, and the flags after any change of all four inputs equal the XOR of old and new levels.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| modem_in | input | LINES (4) | Asynchronous modem control lines |
| rd_en | input | 1 | One-cycle host read strobe; clears change flags at the edge |
| irq_en | input | 1 | Interrupt enable |
| rd_data | output | 2*LINES (8) | Status byte: {levels, change flags} |
| irq | output | 1 | Interrupt request |

## Verification
If the delayed copy of a synchronized level is wrong, a phantom or missing flag appears in `rd_data[3:0]` one edge after the level bits settle. The bench sweeps every pair of old and new input patterns and checks the flags against their XOR at that exact cycle. A wrong clear or priority decision shows in the cycle after the read strobe. An interrupt gating fault shows in the same cycle as the flags.

// File: rtl/msr_pkg.sv
package msr_pkg;
  // default number of monitored modem lines
  localparam int unsigned MSR_LINES       = 4;
  // synchronizer depth for asynchronous inputs
  localparam int unsigned MSR_SYNC_STAGES = 2;
endpackage

// File: rtl/msr_line_sync.sv
module msr_line_sync #(
  parameter int unsigned WIDTH  = msr_pkg::MSR_LINES,
  parameter int unsigned STAGES = msr_pkg::MSR_SYNC_STAGES
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) chain[0] <= async_in;

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) chain[g] <= chain[g-1];
  end

  assign sync_out = chain[LAST];
endmodule

// File: rtl/msr_change_flags.sv
module msr_change_flags #(
  parameter int unsigned WIDTH = msr_pkg::MSR_LINES
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  input  logic             rd_clr,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] level_q;
  logic [WIDTH-1:0] toggled;

  assign toggled = level ^ level_q;

  always_ff @(posedge clk) begin
    level_q <= level;
    if (rst) flags <= '0;
    else     flags <= (flags & ~{WIDTH{rd_clr}}) | toggled;
  end

  // R2
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|toggled) |=> ((flags & $past(toggled)) == $past(toggled)));

  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_clr |=> (($past(flags) & ~flags) == '0));

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && toggled == '0) |=> (flags == '0));

  // R9
  no_phantom_chk: assert property (@(posedge clk) disable iff (rst)
    !$rose(rst) |-> ((flags & ~$past(flags) & ~$past(toggled)) == '0));
endmodule

// File: rtl/modem_status_reg.sv
module modem_status_reg #(
  parameter int unsigned LINES       = msr_pkg::MSR_LINES,
  parameter int unsigned SYNC_STAGES = msr_pkg::MSR_SYNC_STAGES
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LINES-1:0]   modem_in,
  input  logic               rd_en,
  input  logic               irq_en,
  output logic [2*LINES-1:0] rd_data,
  output logic               irq
);
  logic [LINES-1:0] level;
  logic [LINES-1:0] flags;

  msr_line_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .async_in (modem_in),
    .sync_out (level)
  );

  msr_change_flags #(.WIDTH(LINES)) u_flags (
    .clk    (clk),
    .rst    (rst),
    .level  (level),
    .rd_clr (rd_en),
    .flags  (flags)
  );

  assign rd_data = {level, flags};
  assign irq     = irq_en & (|flags);

  if (SYNC_STAGES == 2) begin : g_lag_chk
    // R1
    level_lag_chk: assert property (@(posedge clk) disable iff (rst)
      !$rose(rst) |-> (rd_data[2*LINES-1:LINES] == $past(modem_in, 2)));
  end

  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_en |-> !irq);
endmodule

// File: tb/modem_status_reg_test.sv
module modem_status_reg_test;
  localparam int L = 4;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic           rst = 1'b1;
  logic [L-1:0]   lines = '0;
  logic           rd_en = 1'b0;
  logic           irq_en = 1'b0;
  logic [2*L-1:0] rd_data;
  logic           irq;

  int checks = 0;
  int fails  = 0;

  modem_status_reg uut (
    .clk(clk), .rst(rst), .modem_in(lines), .rd_en(rd_en),
    .irq_en(irq_en), .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // called at or just after a falling edge
  task automatic host_read(output logic [7:0] v);
    rd_en = 1'b1;
    #1 v = rd_data;
    tick(1);
    rd_en = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    lines = 4'b1010;
    tick(4);
    rst = 1'b0;
    tick(1); #1;
    chk("R7 reset value", rd_data, {4'b1010, 4'b0000});
    chk("R7 irq after reset", {7'b0, irq}, 8'h00);

    irq_en = 1'b1;
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        logic [3:0] av, bv;
        av = 4'(a); bv = 4'(b);
        lines = av;
        tick(4);
        host_read(v);
        #1 chk("R4 cleared before step", rd_data, {av, 4'b0000});
        lines = bv;
        tick(2); #1;
        chk("R1 level after two edges", rd_data, {bv, 4'b0000});
        tick(1); #1;
        chk("R2 R9 flags", rd_data, {bv, av ^ bv});
        chk("R6 irq", {7'b0, irq}, {7'b0, av != bv});
        host_read(v);
        chk("R5 pre-clear read data", v, {bv, av ^ bv});
        #1 chk("R4 flags cleared", rd_data, {bv, 4'b0000});
      end
    end

    // R3 sticky through toggle back
    lines = 4'b0000; tick(4); host_read(v);
    lines = 4'b0001; tick(3);
    lines = 4'b0000; tick(3); #1;
    chk("R3 flag kept after toggle back", rd_data, {4'b0000, 4'b0001});
    lines = 4'b1000; tick(3); #1;
    chk("R3 R9 second line adds flag", rd_data, {4'b1000, 4'b1001});
    irq_en = 1'b0; #1;
    chk("R6 irq masked", {7'b0, irq}, 8'h00);
    irq_en = 1'b1; #1;
    chk("R6 irq enabled", {7'b0, irq}, 8'h01);

    // R4 change detected in the read cycle wins
    tick(1); host_read(v);
    lines = 4'b0000; tick(4); host_read(v);
    lines = 4'b0001; tick(3);
    lines = 4'b0101; tick(2);
    host_read(v);
    chk("R5 read data in collision cycle", v, {4'b0101, 4'b0001});
    #1 chk("R4 same-cycle change kept", rd_data, {4'b0101, 4'b0100});

    // R8 read with no flags set
    host_read(v);
    #1 chk("R8 idle read before", rd_data, {4'b0101, 4'b0000});
    host_read(v);
    chk("R8 idle read value", v, {4'b0101, 4'b0000});
    #1 chk("R8 idle read after", rd_data, {4'b0101, 4'b0000});

    // R7 reset clears pending flags, levels keep tracking
    lines = 4'b0011; tick(3);
    rst = 1'b1; lines = 4'b1100; tick(3);
    rst = 1'b0; tick(2); #1;
    chk("R7 flags cleared by reset", rd_data, {4'b1100, 4'b0000});

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule